// File: doc/BRIEF.md
# Reloadable Microsecond Interval Timer

This block is an up-counting interval timer that sits behind a small register port. Software places a reload value in one register, then starts the timer through a control/status register. While running, the counter moves forward by one on every cycle in which the tick-enable input is high (nominally once per microsecond). When it steps past all ones it takes the reload value again, so the interval is 2^W minus the reload value. Each wrap flags completion and can raise an interrupt.

The control register also carries two one-shot commands that are acted on and never stored. The first copies the reload value into the counter. The second advances a stopped counter by one so that software can walk it through a wrap. A wrap that happens while the previous completion is still unacknowledged sets a sticky error flag. The interrupt request follows completion and enable: it is dropped whenever both are not set.

Top module: `ivl_timer`

## Requirements
- R1: While reset is held and after it is released, every register reads zero and `irq_o` is low.
- R2: With run set, each cycle with `tick_en` high and no control write adds one to the count. A control write in the same cycle takes precedence and the tick is dropped.
- R3: With run clear, ticks leave the count unchanged. A write to the count address (1) has no effect. A control write with run set and transfer clear resumes from the current count.
- R4: A step from all ones loads the reload value, so from reload value V the wrap comes on tick 2^W − V.
- R5: A wrap sets done (bit 7) if done is clear, otherwise sets error (bit 31). Error stays set until software clears it.
- R6: In a control write, a 1 in bit 7 clears done and a 1 in bit 31 clears error. A 0 leaves that flag as it is. Bit 0 (run) and bit 6 (interrupt enable) take the written value.
- R7: A control write with bit 4 (transfer) set copies the reload value into the count, whether run is set or clear.
- R8: A control write with run clear and bit 5 (single step) set adds one to the count, after any transfer in the same write. A step from all ones behaves as a wrap under R4, R5 and R9. Single step is ignored when run is written as 1.
- R9: On a wrap, `irq_o` becomes the value of interrupt enable. After any control write, `irq_o` is low unless done and interrupt enable are both set.
- R10: Address 0 reads run at bit 0, interrupt enable at bit 6, done at bit 7 and error at bit 31, with all other bits zero (transfer and single step read as zero). Address 1 reads the live count, address 2 reads the reload value, and address 3 reads zero.
- R11: A write to address 2 sets the reload value. A wrap in the same cycle uses the previous reload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | One-cycle count enable, nominally 1 MHz |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control/status, 1 count, 2 reload |
| reg_wdata | input | W | Write data |
| reg_rdata | output | W | Read data for `reg_addr`, combinational |
| irq_o | output | 1 | Interrupt request, registered |

## Verification
Every write and every tick is applied at one rising edge, and its effect on the count, the flags and `irq_o` is visible at the next edge. Read data follows `reg_addr` in the same cycle with no added latency. Each stimulus is therefore held across exactly one rising edge. At the following falling edge the bench drops the strobes, steps the address through all four registers and compares them and `irq_o` with a cycle model it updates once per edge. Directed runs place the reload value a few counts below all ones, so that wraps, error escalation and single-step wraps arrive after a known small number of ticks.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTL = 2'd0,
    ADR_CNT = 2'd1,
    ADR_REL = 2'd2,
    ADR_NUL = 2'd3
  } reg_adr_e;

  // control/status bit positions (error sits at the top bit, W-1)
  localparam int B_RUN  = 0;
  localparam int B_XFR  = 4;
  localparam int B_SGL  = 5;
  localparam int B_IE   = 6;
  localparam int B_DONE = 7;
endpackage

// File: rtl/ivl_timer_rstsync.sv
module ivl_timer_rstsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else        sr_q <= {sr_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sr_q[STAGES-1];
endmodule

// File: rtl/ivl_timer_count.sv
module ivl_timer_count #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  logic         cmd_run,
  input  logic         cmd_xfr,
  input  logic         cmd_sgl,
  input  logic         run_q,
  input  logic         tick_en,
  input  logic         rel_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count_q,
  output logic [W-1:0] reload_q,
  output logic         wrap
);
  logic [W-1:0] count_d, reload_d, base;
  logic         stepping;

  always_comb begin
    base     = (ctl_wr && cmd_xfr) ? reload_q : count_q;
    stepping = ctl_wr ? (!cmd_run && cmd_sgl) : (run_q && tick_en);
    wrap     = stepping && (&base);
    if (!stepping)  count_d = base;
    else if (wrap)  count_d = reload_q;
    else            count_d = base + {{(W-1){1'b0}}, 1'b1};
    reload_d = rel_wr ? wdata : reload_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      reload_q <= '0;
    end else begin
      count_q  <= count_d;
      reload_q <= reload_d;
    end
  end
endmodule

// File: rtl/ivl_timer_csr.sv
module ivl_timer_csr (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic w_run,
  input  logic w_ie,
  input  logic w_done_clr,
  input  logic w_err_clr,
  input  logic wrap,
  output logic run_q,
  output logic ie_q,
  output logic done_q,
  output logic err_q,
  output logic irq_q
);
  logic run_d, ie_d, done_d, err_d, irq_d;
  logic done_c, err_c;

  always_comb begin
    run_d  = ctl_wr ? w_run : run_q;
    ie_d   = ctl_wr ? w_ie  : ie_q;
    done_c = done_q & ~(ctl_wr & w_done_clr);
    err_c  = err_q  & ~(ctl_wr & w_err_clr);
    done_d = done_c | (wrap & ~done_c);
    err_d  = err_c  | (wrap &  done_c);
    if (ctl_wr)     irq_d = (irq_q | (wrap & ie_d)) & done_d & ie_d;
    else if (wrap)  irq_d = ie_q;
    else            irq_d = irq_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      ie_q   <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_d;
      ie_q   <= ie_d;
      done_q <= done_d;
      err_q  <= err_d;
      irq_q  <= irq_d;
    end
  end
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
#(
  parameter int W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [W-1:0]      reg_wdata,
  output logic [W-1:0]      reg_rdata,
  output logic              irq_o
);
  localparam int B_ERR = W - 1;

  logic         rs_n;
  logic         ctl_wr, rel_wr, wrap;
  logic         run_q, ie_q, done_q, err_q;
  logic [W-1:0] count_q, reload_q, ctl_view;

  ivl_timer_rstsync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rs_n)
  );

  assign ctl_wr = reg_wr && (reg_addr == ADR_CTL);
  assign rel_wr = reg_wr && (reg_addr == ADR_REL);

  ivl_timer_count #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rs_n), .ctl_wr(ctl_wr),
    .cmd_run(reg_wdata[B_RUN]), .cmd_xfr(reg_wdata[B_XFR]),
    .cmd_sgl(reg_wdata[B_SGL]), .run_q(run_q), .tick_en(tick_en),
    .rel_wr(rel_wr), .wdata(reg_wdata),
    .count_q(count_q), .reload_q(reload_q), .wrap(wrap)
  );

  ivl_timer_csr u_csr (
    .clk(clk), .rst_n(rs_n), .ctl_wr(ctl_wr),
    .w_run(reg_wdata[B_RUN]), .w_ie(reg_wdata[B_IE]),
    .w_done_clr(reg_wdata[B_DONE]), .w_err_clr(reg_wdata[B_ERR]),
    .wrap(wrap), .run_q(run_q), .ie_q(ie_q), .done_q(done_q),
    .err_q(err_q), .irq_q(irq_o)
  );

  always_comb begin
    ctl_view         = '0;
    ctl_view[B_RUN]  = run_q;
    ctl_view[B_IE]   = ie_q;
    ctl_view[B_DONE] = done_q;
    ctl_view[B_ERR]  = err_q;
    case (reg_addr)
      ADR_CTL: reg_rdata = ctl_view;
      ADR_CNT: reg_rdata = count_q;
      ADR_REL: reg_rdata = reload_q;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rs_n,
  input logic         tick_en,
  input logic         ctl_wr,
  input logic         rel_wr,
  input logic [W-1:0] wdata,
  input logic         run_q,
  input logic         ie_q,
  input logic         done_q,
  input logic         err_q,
  input logic         irq_o,
  input logic [W-1:0] count_q,
  input logic [W-1:0] reload_q
);
  a_r9_irq_needs_done_ie: assert property (@(posedge clk) disable iff (!rs_n)
    irq_o |-> (done_q && ie_q));

  a_r2_tick_increments: assert property (@(posedge clk) disable iff (!rs_n)
    (run_q && tick_en && !ctl_wr && !(&count_q)) |=> (count_q == $past(count_q) + 1'b1));

  a_r4_wrap_reloads: assert property (@(posedge clk) disable iff (!rs_n)
    (run_q && tick_en && !ctl_wr && (&count_q)) |=> (count_q == $past(reload_q) && done_q));

  a_r3_hold_stopped: assert property (@(posedge clk) disable iff (!rs_n)
    (!run_q && !ctl_wr) |=> $stable(count_q));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rs_n)
    (err_q && !(ctl_wr && wdata[W-1])) |=> err_q);

  a_r11_reload_holds: assert property (@(posedge clk) disable iff (!rs_n)
    !rel_wr |=> $stable(reload_q));
endmodule

bind ivl_timer ivl_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rs_n(rs_n), .tick_en(tick_en), .ctl_wr(ctl_wr),
  .rel_wr(rel_wr), .wdata(reg_wdata), .run_q(run_q), .ie_q(ie_q),
  .done_q(done_q), .err_q(err_q), .irq_o(irq_o),
  .count_q(count_q), .reload_q(reload_q)
);

// File: tb/sim_ivl_timer.sv
module sim_ivl_timer;
  localparam int W = 32;
  localparam logic [W-1:0] ONES = '1;

  logic         clk, rst_n, tick_en, reg_wr, irq_o;
  logic [1:0]   reg_addr;
  logic [W-1:0] reg_wdata, reg_rdata;

  int n_chk, n_bad, n_cyc;

  // reference state
  logic [W-1:0] m_cnt, m_rel;
  logic         m_run, m_ie, m_done, m_err, m_irq;

  ivl_timer #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_o(irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [W-1:0] ctl_word(input logic run, xfr, sgl, ie,
                                            input logic dclr, eclr);
    logic [W-1:0] v;
    v = '0;
    v[0] = run; v[4] = xfr; v[5] = sgl; v[6] = ie; v[7] = dclr; v[W-1] = eclr;
    return v;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step(input logic w, input logic [1:0] a,
                            input logic [W-1:0] d, input logic t);
    logic ctl, stp, wr;
    logic [W-1:0] c;
    ctl = w && (a == 2'd0);
    stp = ctl ? (!d[0] && d[5]) : (m_run && t);
    c   = (ctl && d[4]) ? m_rel : m_cnt;
    wr  = stp && (c == ONES);
    if (stp) c = wr ? m_rel : c + 1;
    if (ctl) begin
      if (d[7])   m_done = 1'b0;
      if (d[W-1]) m_err  = 1'b0;
      m_run = d[0];
      m_ie  = d[6];
    end
    if (wr) begin
      if (m_done) m_err = 1'b1;
      else        m_done = 1'b1;
      m_irq = m_ie;
    end
    if (ctl && !(m_done && m_ie)) m_irq = 1'b0;
    if (w && a == 2'd2) m_rel = d;
    m_cnt = c;
  endtask

  task automatic cmp_all(input string tag);
    logic [W-1:0] cv;
    cv = '0;
    cv[0] = m_run; cv[6] = m_ie; cv[7] = m_done; cv[W-1] = m_err;
    reg_wr = 1'b0; tick_en = 1'b0;
    chk({tag, " irq"}, {{(W-1){1'b0}}, irq_o}, {{(W-1){1'b0}}, m_irq});
    reg_addr = 2'd0; #1 chk({tag, " R10 ctl"}, reg_rdata, cv);
    reg_addr = 2'd1; #1 chk({tag, " R10 cnt"}, reg_rdata, m_cnt);
    reg_addr = 2'd2; #1 chk({tag, " R10 rel"}, reg_rdata, m_rel);
    reg_addr = 2'd3; #1 chk({tag, " R10 nul"}, reg_rdata, '0);
  endtask

  // one stimulus held over one rising edge, checked at the next falling edge
  task automatic op(input logic w, input logic [1:0] a, input logic [W-1:0] d,
                    input logic t, input string tag);
    reg_wr = w; reg_addr = a; reg_wdata = d; tick_en = t;
    @(posedge clk);
    model_step(w, a, d, t);
    @(negedge clk);
    cmp_all(tag);
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) op(1'b0, 2'd0, '0, 1'b1, tag);
  endtask

  initial begin
    n_cyc = 0;
    forever begin
      @(posedge clk);
      n_cyc++;
      if (n_cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", n_cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    logic [W-1:0] d;
    int r;
    n_chk = 0; n_bad = 0;
    void'($urandom(32'd5171));
    m_cnt = '0; m_rel = '0; m_run = 0; m_ie = 0; m_done = 0; m_err = 0; m_irq = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0; tick_en = 1'b0;
    repeat (3) @(negedge clk);
    cmp_all("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cmp_all("R1 after reset");

    // R11 reload, R7 transfer while stopped
    op(1'b1, 2'd2, 32'hFFFF_FFFA, 1'b0, "R11 reload write");
    op(1'b1, 2'd0, ctl_word(0,1,0,0,0,0), 1'b1, "R7 transfer stopped");
    // R2 count, R4 wrap after 2^W - V ticks, R9 irq on wrap
    op(1'b1, 2'd0, ctl_word(1,0,0,1,0,0), 1'b1, "R2 tick dropped on ctl write");
    ticks(5, "R2 counting");
    ticks(1, "R4 R5 R9 first wrap");
    ticks(6, "R5 error escalation");
    // R3 stop, tick ignored, count write ignored
    op(1'b1, 2'd0, ctl_word(0,0,0,1,0,0), 1'b0, "R9 irq kept done and ie");
    ticks(3, "R3 hold stopped");
    op(1'b1, 2'd1, 32'h1234_5678, 1'b1, "R3 count write ignored");
    // R6 write-one-to-clear
    op(1'b1, 2'd0, ctl_word(0,0,0,1,1,0), 1'b0, "R6 clear done R9 irq drop");
    op(1'b1, 2'd0, ctl_word(0,0,0,1,0,1), 1'b0, "R6 clear error");
    // R8 single step through a wrap with transfer in the same write
    op(1'b1, 2'd2, ONES, 1'b0, "R11 reload ones");
    op(1'b1, 2'd0, ctl_word(0,1,1,1,0,0), 1'b0, "R8 xfr plus step wrap");
    op(1'b1, 2'd0, ctl_word(0,0,1,1,0,0), 1'b0, "R8 step wrap err");
    op(1'b1, 2'd0, ctl_word(1,0,1,1,1,1), 1'b0, "R8 step ignored when run");
    // R9 wrap without ie clears request
    op(1'b1, 2'd0, ctl_word(1,0,0,0,0,0), 1'b0, "R9 ie off");
    ticks(1, "R9 wrap without ie");
    // R3 resume from current count
    op(1'b1, 2'd2, 32'hFFFF_FF00, 1'b0, "R11 reload");
    op(1'b1, 2'd0, ctl_word(0,0,0,0,1,1), 1'b1, "R3 stop");
    op(1'b1, 2'd0, ctl_word(1,0,0,0,0,0), 1'b0, "R3 resume");
    ticks(2, "R3 resumed counting");
    // R7 transfer while running, R11 reload written at a wrap
    op(1'b1, 2'd2, 32'hFFFF_FFFE, 1'b0, "R11 reload");
    op(1'b1, 2'd0, ctl_word(1,1,0,1,0,0), 1'b1, "R7 transfer running");
    ticks(1, "R2 count");
    op(1'b1, 2'd2, 32'h0000_0010, 1'b1, "R11 old reload used on wrap");

    // constrained random
    for (int k = 0; k < 4000; k++) begin
      r = $urandom % 16;
      if (r < 6) op(1'b0, 2'($urandom), '0, 1'b1, "R2 R4 random tick");
      else if (r < 9) begin
        d = $urandom & 32'h7FFF_FF0E;
        d[0] = ($urandom % 4) != 0; d[4] = ($urandom % 3) == 0;
        d[5] = $urandom % 2;        d[6] = $urandom % 2;
        d[7] = ($urandom % 4) == 0; d[W-1] = ($urandom % 4) == 0;
        op(1'b1, 2'd0, d, 1'($urandom), "R5 R6 R7 R8 R9 random ctl");
      end else if (r < 11) begin
        d = (($urandom % 4) == 0) ? $urandom : (32'hFFFF_FFF0 | ($urandom % 16));
        op(1'b1, 2'd2, d, 1'($urandom), "R11 random reload");
      end else if (r == 11) op(1'b1, 2'd1, $urandom, 1'($urandom), "R3 random count write");
      else op(1'b1, 2'd3, $urandom, 1'($urandom), "R10 random idle");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule